// File: doc/BRIEF.md
# Coprocessor-0 Hazard Spacing Monitor

This block observes a stream of retired instructions, one per cycle when a valid strobe is high, each reduced to a small instruction-class code. It finds pairs in which a later instruction depends on a system-control state change made by an earlier one, and the two are too close together for the later one to see that change. Spacing is the number of valid instructions that retire strictly between the two. Each kind of pair has its own minimum spacing.

The block only detects and reports. It does not stall anything, and it holds no translation, watch or address-space state. For each tracked producing class it keeps a small saturating counter. The counter holds the number of valid instructions seen since that class last retired. A consumer is flagged when a relevant producer's counter is below the minimum spacing for that pair. A flag appears as a single-cycle pulse, together with the class codes of both instructions.

Top module: `cp0_hazard_monitor`

## Requirements
- R1: Class codes on `cls_i` are: 0 unrelated, 1 watch write, 2 indexed TLB write, 3 random TLB write, 4 EntryHi write, 5 EntryLo write, 6 Index write, 7 TLB probe, 8 TLB read, 9 move-from-coprocessor-0, 10 translated instruction fetch, 11 load/store. Codes 12 to 15 are unrelated. After reset, every counter is saturated and the outputs are zero, so no consumer flags until a producer retires.
- R2: A watch write followed by a fetch flags when fewer than 2 valid instructions lie between them.
- R3: A TLB write of either kind followed by a fetch flags when fewer than 3 lie between them. The reported producer is the code of the latest TLB write.
- R4: An EntryHi write followed by an indexed TLB write, a random TLB write or a TLB probe flags when fewer than 1 lies between them.
- R5: An EntryHi write flags a load/store with fewer than 1 between them, and a fetch with fewer than 3 between them.
- R6: An Index write flags a TLB read or an indexed TLB write with fewer than 1 between them. It never flags a random TLB write.
- R7: Zero-spacing pairs never flag. These are: watch write then load/store, TLB write then load/store, EntryLo write then TLB write, and TLB probe or read then move-from-coprocessor-0.
- R8: Cycles with `valid_i` low advance no counter and never produce a flag, whatever `cls_i` holds.
- R9: A producer that retires again restarts its own counter at zero.
- R10: When one consumer violates several pairs, the report names the most recent producer.
- R11: `viol_o` pulses for one cycle, in the cycle after the offending consumer is accepted. `prod_cls_o` and `cons_cls_o` carry the two class codes during the pulse and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A retired instruction is present this cycle |
| cls_i | input | 4 | Instruction class code |
| viol_o | output | 1 | Spacing violation pulse |
| prod_cls_o | output | 4 | Class of the earlier instruction of the violated pair |
| cons_cls_o | output | 4 | Class of the later instruction of the violated pair |

## Verification
The assertions assume that `cls_i` is a defined 4-bit value whenever `valid_i` is high. They also assume that reset is held for at least one clock edge before the stream starts, so that every counter begins saturated. The bench drives inputs only on falling edges and holds reset from time zero. Between scenarios it retires four unrelated instructions, so that each scenario starts from saturated counters. This keeps every spacing the bench expects equal to the count of instructions it issued.

// File: rtl/cp0_hazard_monitor.sv
`timescale 1ns/1ps
module cp0_hazard_monitor #(
  parameter int CLS_W = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             viol_o,
  output logic [CLS_W-1:0] prod_cls_o,
  output logic [CLS_W-1:0] cons_cls_o
);
  localparam logic [CLS_W-1:0] C_WATCH = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_TLBWI = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_TLBWR = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_EHI   = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_IDX   = CLS_W'(6);
  localparam logic [CLS_W-1:0] C_TLBP  = CLS_W'(7);
  localparam logic [CLS_W-1:0] C_TLBR  = CLS_W'(8);
  localparam logic [CLS_W-1:0] C_FETCH = CLS_W'(10);
  localparam logic [CLS_W-1:0] C_LDST  = CLS_W'(11);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SP_WATCH_IF = CNT_W'(2);
  localparam logic [CNT_W-1:0] SP_TLBW_IF  = CNT_W'(3);
  localparam logic [CNT_W-1:0] SP_EHI_IF   = CNT_W'(3);
  localparam logic [CNT_W-1:0] SP_EHI_TLB  = CNT_W'(1);
  localparam logic [CNT_W-1:0] SP_EHI_LS   = CNT_W'(1);
  localparam logic [CNT_W-1:0] SP_IDX_TLB  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_watch, cnt_tlbw, cnt_ehi, cnt_idx;
  logic [CLS_W-1:0] tlbw_code;

  wire is_fetch = cls_i == C_FETCH;
  wire is_ldst  = cls_i == C_LDST;
  wire is_tlbwi = cls_i == C_TLBWI;
  wire is_tlbw  = is_tlbwi || cls_i == C_TLBWR;
  wire is_tlbp  = cls_i == C_TLBP;
  wire is_tlbr  = cls_i == C_TLBR;

  wire v_watch = valid_i && is_fetch && cnt_watch < SP_WATCH_IF;
  wire v_tlbw  = valid_i && is_fetch && cnt_tlbw < SP_TLBW_IF;
  wire v_ehi   = valid_i && ((is_fetch && cnt_ehi < SP_EHI_IF) ||
                             ((is_tlbw || is_tlbp) && cnt_ehi < SP_EHI_TLB) ||
                             (is_ldst && cnt_ehi < SP_EHI_LS));
  wire v_idx   = valid_i && (is_tlbr || is_tlbwi) && cnt_idx < SP_IDX_TLB;

  logic             hit;
  logic [CNT_W-1:0] best;
  logic [CLS_W-1:0] sel;

  always_comb begin
    hit  = 1'b0;
    best = CNT_MAX;
    sel  = '0;
    if (v_watch) begin
      hit = 1'b1; best = cnt_watch; sel = C_WATCH;
    end
    if (v_tlbw && (!hit || cnt_tlbw < best)) begin
      hit = 1'b1; best = cnt_tlbw; sel = tlbw_code;
    end
    if (v_ehi && (!hit || cnt_ehi < best)) begin
      hit = 1'b1; best = cnt_ehi; sel = C_EHI;
    end
    if (v_idx && (!hit || cnt_idx < best)) begin
      hit = 1'b1; best = cnt_idx; sel = C_IDX;
    end
  end

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic restart);
    if (restart) return '0;
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_watch  <= CNT_MAX;
      cnt_tlbw   <= CNT_MAX;
      cnt_ehi    <= CNT_MAX;
      cnt_idx    <= CNT_MAX;
      tlbw_code  <= C_TLBWI;
      viol_o     <= 1'b0;
      prod_cls_o <= '0;
      cons_cls_o <= '0;
    end else begin
      viol_o     <= hit;
      prod_cls_o <= hit ? sel : '0;
      cons_cls_o <= hit ? cls_i : '0;
      if (valid_i) begin
        cnt_watch <= step(cnt_watch, cls_i == C_WATCH);
        cnt_tlbw  <= step(cnt_tlbw, is_tlbw);
        cnt_ehi   <= step(cnt_ehi, cls_i == C_EHI);
        cnt_idx   <= step(cnt_idx, cls_i == C_IDX);
        if (is_tlbw) tlbw_code <= cls_i;
      end
    end
  end
endmodule

// File: rtl/cp0_hazard_monitor_chk.sv
`timescale 1ns/1ps
module cp0_hazard_monitor_chk #(
  parameter int CLS_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             valid_i,
  input logic [CLS_W-1:0] cls_i,
  input logic             viol_o,
  input logic [CLS_W-1:0] prod_cls_o,
  input logic [CLS_W-1:0] cons_cls_o
);
  wire prod_ok = prod_cls_o == CLS_W'(1) || prod_cls_o == CLS_W'(2) ||
                 prod_cls_o == CLS_W'(3) || prod_cls_o == CLS_W'(4) ||
                 prod_cls_o == CLS_W'(6);
  wire cons_ok = cons_cls_o == CLS_W'(2) || cons_cls_o == CLS_W'(3) ||
                 cons_cls_o == CLS_W'(7) || cons_cls_o == CLS_W'(8) ||
                 cons_cls_o == CLS_W'(10) || cons_cls_o == CLS_W'(11);

  assert_no_flag_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !viol_o);
  assert_idle_never_flags_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> !viol_o);
  assert_cons_matches_input_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    viol_o |-> $past(valid_i) && cons_cls_o == $past(cls_i));
  assert_quiet_codes_zero_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !viol_o |-> prod_cls_o == '0 && cons_cls_o == '0);
  assert_only_real_pairs_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    viol_o |-> prod_ok && cons_ok);
  assert_idx_not_random_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    viol_o && prod_cls_o == CLS_W'(6) |-> cons_cls_o == CLS_W'(8) || cons_cls_o == CLS_W'(2));
endmodule

bind cp0_hazard_monitor cp0_hazard_monitor_chk u_chk (.*);

// File: tb/cp0_hazard_monitor_tb.sv
`timescale 1ns/1ps
module cp0_hazard_monitor_tb;
  localparam logic [3:0] OTH = 0, WAT = 1, TWI = 2, TWR = 3, EHI = 4, ELO = 5,
                         IDX = 6, TBP = 7, TBR = 8, MFC = 9, FET = 10, LDS = 11;
  logic clk = 0, rst = 1, valid = 0;
  logic [3:0] cls = 0;
  logic viol;
  logic [3:0] prod, cons;
  int nchk = 0, nfail = 0;

  cp0_hazard_monitor u_dut (.clk_i(clk), .rst_i(rst), .valid_i(valid), .cls_i(cls),
                            .viol_o(viol), .prod_cls_o(prod), .cons_cls_o(cons));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic ev, input logic [3:0] ep, input logic [3:0] ec);
    nchk++;
    if (viol !== ev || prod !== ep || cons !== ec) begin
      nfail++;
      $display("FAIL %s: got viol=%0b prod=%0d cons=%0d expected viol=%0b prod=%0d cons=%0d",
               req, viol, prod, cons, ev, ep, ec);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] c);
    @(negedge clk); valid = v; cls = c;
    @(posedge clk); #1;
    @(negedge clk); valid = 0; cls = 0;
  endtask

  task automatic feed(input logic [3:0] c); issue(1'b1, c); endtask
  task automatic none(input string req, input logic [3:0] c); feed(c); chk(req, 0, 0, 0); endtask
  task automatic hit(input string req, input logic [3:0] c, input logic [3:0] p);
    feed(c); chk(req, 1, p, c);
  endtask
  task automatic flush(); for (int i = 0; i < 4; i++) feed(OTH); endtask

  task automatic t_reset();
    chk("R1 reset", 0, 0, 0);
    none("R1 fetch after reset", FET);
    none("R1 tlbwi after reset", TWI);
    flush();
  endtask

  task automatic t_watch();
    feed(WAT); hit("R2 gap0", FET, WAT);
    none("R11 pulse ends", OTH);
    flush(); feed(WAT); feed(OTH); hit("R2 gap1", FET, WAT);
    flush(); feed(WAT); feed(OTH); feed(OTH); none("R2 gap2", FET);
    flush();
  endtask

  task automatic t_tlbw();
    feed(TWR); feed(OTH); feed(OTH); hit("R3 gap2 random", FET, TWR);
    flush(); feed(TWI); feed(OTH); feed(OTH); feed(OTH); none("R3 gap3", FET);
    flush(); feed(TWI); hit("R3 gap0 indexed", FET, TWI);
    flush();
  endtask

  task automatic t_ehi();
    feed(EHI); hit("R4 ehi-tlbwi", TWI, EHI); flush();
    feed(EHI); hit("R4 ehi-tlbwr", TWR, EHI); flush();
    feed(EHI); hit("R4 ehi-tlbp", TBP, EHI); flush();
    feed(EHI); feed(OTH); none("R4 ehi gap1 tlbp", TBP); flush();
    feed(EHI); hit("R5 ehi-ldst", LDS, EHI); flush();
    feed(EHI); feed(OTH); none("R5 ehi gap1 ldst", LDS); flush();
    feed(EHI); feed(OTH); feed(OTH); hit("R5 ehi gap2 fetch", FET, EHI); flush();
    feed(EHI); feed(OTH); feed(OTH); feed(OTH); none("R5 ehi gap3 fetch", FET); flush();
  endtask

  task automatic t_idx();
    feed(IDX); hit("R6 idx-tlbr", TBR, IDX); flush();
    feed(IDX); hit("R6 idx-tlbwi", TWI, IDX); flush();
    feed(IDX); none("R6 idx-tlbwr", TWR); flush();
    feed(IDX); feed(OTH); none("R6 idx gap1 tlbr", TBR); flush();
  endtask

  task automatic t_zero();
    feed(WAT); none("R7 watch-ldst", LDS); flush();
    feed(TWI); none("R7 tlbw-ldst", LDS); flush();
    feed(ELO); none("R7 elo-tlbwi", TWI); flush();
    feed(TBP); none("R7 tlbp-mfc0", MFC); flush();
    feed(TBR); none("R7 tlbr-mfc0", MFC); flush();
    feed(EHI); none("R7 unrelated code 13", 4'd13); flush();
  endtask

  task automatic t_idle();
    feed(WAT);
    issue(1'b0, FET); chk("R8 invalid fetch", 0, 0, 0);
    issue(1'b0, OTH); issue(1'b0, OTH);
    hit("R8 idle cycles not counted", FET, WAT);
    flush();
  endtask

  task automatic t_restart();
    feed(WAT); feed(OTH); feed(WAT); feed(OTH);
    hit("R9 restart", FET, WAT);
    flush();
  endtask

  task automatic t_prio();
    feed(TWR); feed(EHI); hit("R10 ehi newer than tlbw", FET, EHI); flush();
    feed(EHI); feed(WAT); feed(OTH); hit("R10 watch newer than ehi", FET, WAT); flush();
    feed(WAT); feed(EHI); hit("R10 ehi newer than watch", FET, EHI); flush();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    t_reset(); t_watch(); t_tlbw(); t_ehi(); t_idx();
    t_zero(); t_idle(); t_restart(); t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule